// File: doc/BRIEF.md
# Packet buffer page allocator

This block keeps the books for an on-chip packet buffer that the transmit and receive paths share at page granularity. The buffer holds 24 pages of 256 bytes. Every allocation receives a packet number, and the allocator records how many pages belong to each number. When that number is released, exactly those pages go back to the free pool. The host side issues commands through a small command port: allocate for transmit, reset the allocator, release a given packet, or drop the oldest received frame. It can also write a packet-number register. The host reads back the free page count, the total page count and the allocation result.

The MAC side claims pages for incoming frames through a request port, which answers one cycle later. The MAC also returns the pages of a transmitted frame through a release port. A programmable receive reserve holds pages back from transmit allocation, so that receive traffic cannot be starved. A reserve of zero leaves the whole buffer first come, first served.

Top module: `pa_alloc`

## Requirements
- R1: After hardware reset `free_pages` is 24, `total_pages` is always 24, `pnr` is 0, `busy` is 0, `alloc_done` is 0 and `alloc_failed` is 1.
- R2: A command with `cmd_valid` high is accepted on a rising edge where `busy` is low. `busy` is then high for exactly one cycle. The command executes on the next edge, and its results are visible once `busy` falls. A command presented while `busy` is high is ignored.
- R3: A request of L bytes (`cmd_len`/`rx_alloc_len`, 11 bits) needs ceil(L/256) pages, and a request of 0 bytes needs 1 page.
- R4: A successful transmit allocation (`cmd_op`=0) takes the lowest unused packet number in 0..17. It reports that number on `alloc_pkt`, sets `alloc_done` to 1 and `alloc_failed` to 0, and lowers `free_pages` by the page count.
- R5: A transmit allocation fails if its pages exceed what is available or if all 18 packet numbers are in use. On failure `alloc_done` is 0, `alloc_failed` is 1, `free_pages` is unchanged and no number is consumed. `alloc_failed` is always the inverse of `alloc_done`.
- R6: A transmit allocation may use only `free_pages` minus `rx_reserve` pages, or none if the reserve is at least the free count. Receive allocation ignores the reserve.
- R7: Releasing a packet, either through host command `cmd_op`=2 with `cmd_pkt` or through a MAC pulse on `tx_rel_valid` with `tx_rel_pkt`, returns that packet's pages and frees its number. Releasing an unused number has no effect.
- R8: Command `cmd_op`=3 frees the pages and the number of the packet presented on `rx_top_pkt` when the command is accepted.
- R9: Command `cmd_op`=1 restores `free_pages` to 24, frees every packet number, clears `pnr` and `alloc_done`, and denies any receive request executing in the same cycle.
- R10: A receive request `rx_alloc_req` is answered on the next edge. `rx_alloc_ok` is 1 with the lowest unused number on `rx_alloc_pkt` if enough free pages and a number exist, and 0 otherwise.
- R11: Within one cycle the MAC release is applied first, then the host command, then the receive request, so a host allocation wins the last pages over a simultaneous receive request.
- R12: `pnr_we` loads `pnr_wdata` into `pnr` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| cmd_valid | input | 1 | Host command strobe |
| cmd_op | input | 2 | 0 allocate, 1 reset, 2 release packet, 3 drop receive top |
| cmd_len | input | 11 | Byte count for allocate |
| cmd_pkt | input | 5 | Packet number for release |
| rx_reserve | input | 5 | Pages withheld from transmit |
| pnr_we | input | 1 | Packet-number register write |
| pnr_wdata | input | 5 | Packet-number register data |
| busy | output | 1 | Command executing |
| alloc_done | output | 1 | Allocation interrupt flag |
| alloc_failed | output | 1 | Last allocation failed |
| alloc_pkt | output | 5 | Number granted by last allocation |
| free_pages | output | 5 | Free page count |
| total_pages | output | 5 | Total page count |
| pnr | output | 5 | Packet-number register |
| rx_alloc_req | input | 1 | Receive page request |
| rx_alloc_len | input | 11 | Receive frame byte count |
| rx_top_pkt | input | 5 | Number of oldest received frame |
| rx_alloc_ok | output | 1 | Receive request granted |
| rx_alloc_pkt | output | 5 | Number granted to receive |
| tx_rel_valid | input | 1 | MAC transmit completion release |
| tx_rel_pkt | input | 5 | Number to release |

## Verification
The host command execution and a receive request from the MAC can land on the same clock edge, and both draw on the same free count and the same packet numbers. The bench fills the buffer until only two pages remain. It then places a receive request for two pages on the edge where a two-page transmit allocation executes. The result must show the host granted, the receive request refused and the free count at zero. A second overlap checks that a reset command executing together with a receive request leaves the receive side refused and the pool full.

// File: rtl/pa_pkg.sv
package pa_pkg;
    typedef enum logic [1:0] {
        OP_ALLOC   = 2'd0,
        OP_RESET   = 2'd1,
        OP_RELEASE = 2'd2,
        OP_RX_POP  = 2'd3
    } op_e;
endpackage

// File: rtl/pa_page_count.sv
module pa_page_count #(
    parameter int LEN_W = 11,
    parameter int PG_SH = 8,
    parameter int CNT_W = 4
) (
    input  logic [LEN_W-1:0] len,
    output logic [CNT_W-1:0] pages
);
    localparam int RAW_W = LEN_W - PG_SH + 1;

    logic [LEN_W:0]     sum;
    logic [RAW_W-1:0]   raw;

    assign sum   = {1'b0, len} + (LEN_W+1)'((1 << PG_SH) - 1);
    assign raw   = sum[LEN_W:PG_SH];
    assign pages = (raw == '0) ? CNT_W'(1) : CNT_W'(raw);
endmodule

// File: rtl/pa_first_free.sv
module pa_first_free #(
    parameter int N  = 18,
    parameter int IW = 5
) (
    input  logic [N-1:0]  used,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!used[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/pa_alloc.sv
module pa_alloc
    import pa_pkg::*;
#(
    parameter int NUM_PAGES  = 24,
    parameter int PAGE_BYTES = 256,
    parameter int MAX_PKTS   = 18,
    parameter int PKT_W      = 5,
    parameter int LEN_W      = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic [PKT_W-1:0] cmd_pkt,
    input  logic [$clog2(NUM_PAGES+1)-1:0] rx_reserve,
    input  logic             pnr_we,
    input  logic [PKT_W-1:0] pnr_wdata,
    output logic             busy,
    output logic             alloc_done,
    output logic             alloc_failed,
    output logic [PKT_W-1:0] alloc_pkt,
    output logic [$clog2(NUM_PAGES+1)-1:0] free_pages,
    output logic [$clog2(NUM_PAGES+1)-1:0] total_pages,
    output logic [PKT_W-1:0] pnr,
    input  logic             rx_alloc_req,
    input  logic [LEN_W-1:0] rx_alloc_len,
    input  logic [PKT_W-1:0] rx_top_pkt,
    output logic             rx_alloc_ok,
    output logic [PKT_W-1:0] rx_alloc_pkt,
    input  logic             tx_rel_valid,
    input  logic [PKT_W-1:0] tx_rel_pkt
);
    localparam int FREE_W  = $clog2(NUM_PAGES + 1);
    localparam int PG_SH   = $clog2(PAGE_BYTES);
    localparam int MAX_REQ = ((1 << LEN_W) + PAGE_BYTES - 1) / PAGE_BYTES;
    localparam int CNT_W   = $clog2(MAX_REQ + 1);

    typedef struct packed {
        logic                            busy;
        op_e                             op;
        logic [LEN_W-1:0]                len;
        logic [PKT_W-1:0]                arg;
        logic                            done;
        logic [PKT_W-1:0]                apkt;
        logic [FREE_W-1:0]               free;
        logic [PKT_W-1:0]                pnr;
        logic [MAX_PKTS-1:0]             used;
        logic [MAX_PKTS-1:0][CNT_W-1:0]  pages;
        logic                            rx_ok;
        logic [PKT_W-1:0]                rx_pkt;
    } st_t;

    st_t q, s1, d;

    logic [MAX_PKTS-1:0] used_a;
    logic                h_found, r_found;
    logic [PKT_W-1:0]    h_idx, r_idx;
    logic [CNT_W-1:0]    h_pages, r_pages;
    logic [FREE_W-1:0]   tx_avail;

    function automatic st_t drop_pkt(st_t s, logic [PKT_W-1:0] p);
        st_t r = s;
        if (32'(p) < MAX_PKTS) begin
            if (r.used[p]) begin
                r.free     = r.free + FREE_W'(r.pages[p]);
                r.used[p]  = 1'b0;
                r.pages[p] = '0;
            end
        end
        return r;
    endfunction

    // Numbers in use once the MAC release of this cycle is applied
    always_comb begin
        used_a = q.used;
        if (tx_rel_valid && (32'(tx_rel_pkt) < MAX_PKTS))
            used_a[tx_rel_pkt] = 1'b0;
    end

    pa_page_count #(.LEN_W(LEN_W), .PG_SH(PG_SH), .CNT_W(CNT_W)) u_cnt_h (
        .len(q.len), .pages(h_pages));
    pa_page_count #(.LEN_W(LEN_W), .PG_SH(PG_SH), .CNT_W(CNT_W)) u_cnt_r (
        .len(rx_alloc_len), .pages(r_pages));
    pa_first_free #(.N(MAX_PKTS), .IW(PKT_W)) u_pick_h (
        .used(used_a), .found(h_found), .idx(h_idx));
    pa_first_free #(.N(MAX_PKTS), .IW(PKT_W)) u_pick_r (
        .used(s1.used), .found(r_found), .idx(r_idx));

    // Stage 1: MAC release, then host command and register write
    always_comb begin
        s1       = q;
        s1.rx_ok = 1'b0;
        if (tx_rel_valid)
            s1 = drop_pkt(s1, tx_rel_pkt);
        tx_avail = (s1.free > rx_reserve) ? (s1.free - rx_reserve) : '0;
        if (q.busy) begin
            s1.busy = 1'b0;
            case (q.op)
                OP_ALLOC: begin
                    if (h_found && (FREE_W'(h_pages) <= tx_avail)) begin
                        s1.used[h_idx]  = 1'b1;
                        s1.pages[h_idx] = h_pages;
                        s1.free         = s1.free - FREE_W'(h_pages);
                        s1.done         = 1'b1;
                        s1.apkt         = h_idx;
                    end else begin
                        s1.done = 1'b0;
                    end
                end
                OP_RELEASE, OP_RX_POP: s1 = drop_pkt(s1, q.arg);
                default: ;
            endcase
        end else if (cmd_valid) begin
            s1.busy = 1'b1;
            s1.op   = op_e'(cmd_op);
            s1.len  = cmd_len;
            s1.arg  = (op_e'(cmd_op) == OP_RX_POP) ? rx_top_pkt : cmd_pkt;
        end
        if (pnr_we)
            s1.pnr = pnr_wdata;
    end

    // Stage 2: receive claim, then allocator reset overrides all
    always_comb begin
        d = s1;
        if (rx_alloc_req && r_found && (FREE_W'(r_pages) <= s1.free)) begin
            d.used[r_idx]  = 1'b1;
            d.pages[r_idx] = r_pages;
            d.free         = s1.free - FREE_W'(r_pages);
            d.rx_ok        = 1'b1;
            d.rx_pkt       = r_idx;
        end
        if (q.busy && (q.op == OP_RESET)) begin
            d.used  = '0;
            d.pages = '0;
            d.free  = FREE_W'(NUM_PAGES);
            d.pnr   = '0;
            d.done  = 1'b0;
            d.rx_ok = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.free <= FREE_W'(NUM_PAGES);
        end else begin
            q <= d;
        end
    end

    assign busy         = q.busy;
    assign alloc_done   = q.done;
    assign alloc_failed = ~q.done;
    assign alloc_pkt    = q.apkt;
    assign free_pages   = q.free;
    assign total_pages  = FREE_W'(NUM_PAGES);
    assign pnr          = q.pnr;
    assign rx_alloc_ok  = q.rx_ok;
    assign rx_alloc_pkt = q.rx_pkt;
endmodule

// File: rtl/pa_alloc_chk.sv
module pa_alloc_chk #(
    parameter int NUM_PAGES = 24,
    parameter int FREE_W    = 5,
    parameter int PKT_W     = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic              busy,
    input logic              alloc_done,
    input logic [FREE_W-1:0] free_pages,
    input logic [PKT_W-1:0]  pnr,
    input logic              rx_alloc_req,
    input logic              rx_alloc_ok
);
    logic [1:0] seen_op;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 seen_op <= 2'd0;
        else if (cmd_valid && !busy) seen_op <= cmd_op;
    end

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> busy);

    // R2
    busy_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    // R9
    reset_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && seen_op == 2'd1) |=> (free_pages == FREE_W'(NUM_PAGES) && pnr == '0 && !rx_alloc_ok));

    // R5
    free_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        free_pages <= FREE_W'(NUM_PAGES));

    // R10
    rx_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_alloc_ok |-> $past(rx_alloc_req));

    // R4
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alloc_done) |-> $past(busy));
endmodule

bind pa_alloc pa_alloc_chk #(
    .NUM_PAGES(NUM_PAGES), .FREE_W(FREE_W), .PKT_W(PKT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .busy(busy), .alloc_done(alloc_done), .free_pages(free_pages),
    .pnr(pnr), .rx_alloc_req(rx_alloc_req), .rx_alloc_ok(rx_alloc_ok)
);

// File: tb/pa_alloc_tb.sv
module pa_alloc_tb;
    localparam int NP = 24;
    localparam int MP = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 0;
    logic [1:0] cmd_op = 0;
    logic [10:0] cmd_len = 0;
    logic [4:0] cmd_pkt = 0;
    logic [4:0] rx_reserve = 0;
    logic pnr_we = 0;
    logic [4:0] pnr_wdata = 0;
    logic busy, alloc_done, alloc_failed;
    logic [4:0] alloc_pkt, free_pages, total_pages, pnr;
    logic rx_alloc_req = 0;
    logic [10:0] rx_alloc_len = 0;
    logic [4:0] rx_top_pkt = 0;
    logic rx_alloc_ok;
    logic [4:0] rx_alloc_pkt;
    logic tx_rel_valid = 0;
    logic [4:0] tx_rel_pkt = 0;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    int mfree = NP;
    bit mused [MP];
    int mpages [MP];

    always #4 clk = ~clk;

    pa_alloc u_dut (.*);

    task automatic chk(string req, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int pg(int len);
        int p = (len + 255) / 256;
        return (p == 0) ? 1 : p;
    endfunction

    function automatic int mfirst();
        for (int i = 0; i < MP; i++) if (!mused[i]) return i;
        return -1;
    endfunction

    task automatic mdrop(int p);
        if (p < MP && mused[p]) begin
            mfree += mpages[p];
            mused[p] = 0;
            mpages[p] = 0;
        end
    endtask

    task automatic mreset();
        mfree = NP;
        for (int i = 0; i < MP; i++) begin mused[i] = 0; mpages[i] = 0; end
    endtask

    task automatic issue(int op, int len, int pkt);
        cmd_valid = 1; cmd_op = 2'(op); cmd_len = 11'(len); cmd_pkt = 5'(pkt);
        @(negedge clk);
        cmd_valid = 0;
        chk("R2", "busy after accept", busy, 1);
        @(negedge clk);
        chk("R2", "busy after execute", busy, 0);
    endtask

    task automatic alloc_tx(int len, output int got);
        int p = pg(len);
        int av = (mfree > rx_reserve) ? mfree - rx_reserve : 0;
        int ix = mfirst();
        bit ok = (ix >= 0) && (p <= av);
        issue(0, len, 0);
        chk(ok ? "R4" : "R5", "alloc_done", alloc_done, ok);
        chk("R5", "alloc_failed inverse", alloc_failed, !ok);
        if (ok) begin
            mused[ix] = 1; mpages[ix] = p; mfree -= p;
            chk("R4", "alloc_pkt", alloc_pkt, ix);
        end
        chk("R3", "free_pages", free_pages, mfree);
        got = ok ? ix : -1;
    endtask

    task automatic rx_alloc(int len, output int got);
        int p = pg(len);
        int ix = mfirst();
        bit ok = (ix >= 0) && (p <= mfree);
        rx_alloc_req = 1; rx_alloc_len = 11'(len);
        @(negedge clk);
        rx_alloc_req = 0;
        chk("R10", "rx_alloc_ok", rx_alloc_ok, ok);
        if (ok) begin
            mused[ix] = 1; mpages[ix] = p; mfree -= p;
            chk("R10", "rx_alloc_pkt", rx_alloc_pkt, ix);
        end
        chk("R10", "free after rx", free_pages, mfree);
        got = ok ? ix : -1;
    endtask

    initial begin
        int g, g2;
        mreset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "free_pages", free_pages, NP);
        chk("R1", "total_pages", total_pages, NP);
        chk("R1", "pnr", pnr, 0);
        chk("R1", "busy", busy, 0);
        chk("R1", "alloc_done", alloc_done, 0);
        chk("R1", "alloc_failed", alloc_failed, 1);

        // R3 sweep of byte counts, each released again by host (R7)
        for (int len = 0; len < 2048; len += 17) begin
            alloc_tx(len, g);
            issue(2, 0, g);
            mdrop(g);
            chk("R7", "free after release", free_pages, mfree);
        end
        for (int k = 1; k < 8; k++) begin
            for (int o = -1; o <= 1; o++) begin
                alloc_tx(k * 256 + o, g);
                issue(2, 0, g);
                mdrop(g);
            end
        end

        // R5 number exhaustion with 1-byte packets
        for (int i = 0; i <= MP; i++) alloc_tx(1, g);
        chk("R5", "19th refused", g, -1);
        alloc_tx(2047, g);
        // R4 flag clears on a failed request after a success
        issue(2, 0, 3); mdrop(3);
        alloc_tx(1, g);
        chk("R4", "reused lowest number", g, 3);
        alloc_tx(2000, g);
        chk("R5", "alloc_done cleared on failure", alloc_done, 0);

        // R7 MAC release and unused release
        tx_rel_valid = 1; tx_rel_pkt = 5;
        @(negedge clk);
        tx_rel_valid = 0; mdrop(5);
        chk("R7", "free after MAC release", free_pages, mfree);
        tx_rel_valid = 1; tx_rel_pkt = 5;
        @(negedge clk);
        tx_rel_valid = 0;
        chk("R7", "unused MAC release ignored", free_pages, mfree);
        issue(2, 0, 5);
        chk("R7", "unused host release ignored", free_pages, mfree);

        // R12 register write, R9 reset command clears it
        pnr_we = 1; pnr_wdata = 13;
        @(negedge clk);
        pnr_we = 0;
        chk("R12", "pnr written", pnr, 13);
        issue(1, 0, 0); mreset();
        chk("R9", "free after reset cmd", free_pages, NP);
        chk("R9", "pnr after reset cmd", pnr, 0);
        chk("R9", "alloc_done after reset cmd", alloc_done, 0);

        // R6 receive reserve
        rx_reserve = 20;
        alloc_tx(1025, g);
        chk("R6", "over reserve refused", g, -1);
        alloc_tx(1024, g);
        chk("R6", "within reserve granted", g, 0);
        alloc_tx(1, g);
        chk("R6", "reserve exhausted", g, -1);
        rx_alloc(2047, g);
        chk("R6", "rx ignores reserve", g, 1);
        // R8 drop receive top
        rx_top_pkt = 5'(g);
        issue(3, 0, 0); mdrop(g);
        chk("R8", "free after rx drop", free_pages, mfree);
        rx_reserve = 0;
        issue(1, 0, 0); mreset();

        // R11 host and receive compete for the last pages
        alloc_tx(2047, g);
        alloc_tx(2047, g);
        alloc_tx(1536, g);
        chk("R11", "two pages left", free_pages, 2);
        cmd_valid = 1; cmd_op = 0; cmd_len = 512;
        @(negedge clk);
        cmd_valid = 0;
        rx_alloc_req = 1; rx_alloc_len = 512;
        @(negedge clk);
        rx_alloc_req = 0;
        g2 = mfirst(); mused[g2] = 1; mpages[g2] = 2; mfree -= 2;
        chk("R11", "host wins", alloc_done, 1);
        chk("R11", "host number", alloc_pkt, g2);
        chk("R11", "rx refused", rx_alloc_ok, 0);
        chk("R11", "pool empty", free_pages, 0);

        // R9 reset command overlapping a receive request
        cmd_valid = 1; cmd_op = 1;
        @(negedge clk);
        cmd_valid = 0;
        rx_alloc_req = 1; rx_alloc_len = 1;
        @(negedge clk);
        rx_alloc_req = 0; mreset();
        chk("R9", "rx denied during reset", rx_alloc_ok, 0);
        chk("R9", "pool full", free_pages, NP);

        // R2 command held through busy is ignored
        cmd_valid = 1; cmd_op = 0; cmd_len = 1;
        @(negedge clk);
        chk("R2", "busy", busy, 1);
        @(negedge clk);
        cmd_valid = 0;
        chk("R2", "held command ignored", busy, 0);
        chk("R2", "single allocation", free_pages, NP - 1);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule